// File: doc/BRIEF.md
# UART Enhanced Register Write-Lock Gate

This block is the host-facing register front end of one 16550-style UART channel. It decodes a small host bus (3-bit address, 8-bit write data, single-cycle write strobe, combinational read data) and holds the line-control, interrupt-enable, FIFO-control and modem-control registers. It also holds an enhanced-function register. That register can be reached only while the line-control register holds a fixed access key, 0xBF. The enhanced-function register, the line-control register and the three host-written control registers are driven out to the rest of the UART. The interrupt-identification status comes in from the UART core and is returned on reads.

Bit 4 of the enhanced-function register is the enhanced enable. While it is 1, the extended fields of the control registers accept host writes: interrupt-enable bits 7..4, FIFO-control bits 5..4 and modem-control bits 7..5. While it is 0, those fields keep their stored values and the remaining bits still update. Software can program the extended fields, then clear the enable to freeze them so that legacy drivers cannot disturb them. The serial datapath, FIFOs, divisor latch and interrupt priority are handled elsewhere.

Register addresses: 1 = interrupt enable, 2 = FIFO control on write and interrupt identification on read (enhanced-function register when keyed), 3 = line control, 4 = modem control. Addresses 0, 5, 6 and 7 have no register in this block.

Top module: `uart_efr_gate`

## Requirements
- R1: A synchronous active-high reset clears the enhanced-function, line-control, interrupt-enable, FIFO-control and modem-control registers to 0x00, including every extended field.
- R2: A write to address 2 updates the enhanced-function register only while the line-control register equals 0xBF. Otherwise it updates the FIFO-control register and leaves the enhanced-function register unchanged.
- R3: A read of address 2 returns the enhanced-function register while the line-control register equals 0xBF, and the interrupt-identification view otherwise. Read data is combinational from the current stored state.
- R4: Bits 7 and 6 of the enhanced-function register always read 0 whatever is written. Bits 5..0 store the written value.
- R5: While enhanced-function bit 4 is 0, a write leaves interrupt-enable bits 7..4, FIFO-control bits 5..4 and modem-control bits 7..5 unchanged and updates all other bits of those registers.
- R6: While enhanced-function bit 4 is 1, writes to the interrupt-enable, FIFO-control and modem-control registers update all eight bits.
- R7: Extended field values written with the enable at 1 remain in place after the enable is written back to 0, through any number of later writes.
- R8: The interrupt-identification read returns the core status with bits 5..4 forced to 0 while enhanced-function bit 4 is 0, and passes all bits through while it is 1.
- R9: Addresses 1, 3 and 4 read back the interrupt-enable, line-control and modem-control registers. Addresses 0, 5, 6 and 7 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Single-cycle write strobe |
| host_rdata | output | 8 | Read data for host_addr |
| core_iir | input | 8 | Interrupt identification status from the UART core |
| efr_q | output | 8 | Current enhanced-function register |
| lcr_q | output | 8 | Current line-control register |
| ier_q | output | 8 | Current interrupt-enable register |
| fcr_q | output | 8 | Current FIFO-control register |
| mcr_q | output | 8 | Current modem-control register |

## Verification
Two functions can meet in one cycle: a host write that changes the enhanced-function register, and the combinational read of the same address. The read must return the value from before the write, and the new value must appear only after the edge. The random stimulus keeps the key in the line-control register for long stretches, mixes reads and writes at address 2, and changes the core status every cycle. Each read is compared with a bench model that updates only at the edge, so a read that sees the new value one cycle early is reported.

// File: rtl/uart_efr_pkg.sv
package uart_efr_pkg;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NEXT = 3;               // number of protected registers

    localparam logic [DW-1:0] ACCESS_KEY = 8'hBF;
    localparam int            ENH_BIT    = 4;

    localparam logic [AW-1:0] A_IER = 3'd1;
    localparam logic [AW-1:0] A_FCR = 3'd2;
    localparam logic [AW-1:0] A_LCR = 3'd3;
    localparam logic [AW-1:0] A_MCR = 3'd4;

    localparam logic [DW-1:0] IER_XMASK = 8'hF0;
    localparam logic [DW-1:0] FCR_XMASK = 8'h30;
    localparam logic [DW-1:0] MCR_XMASK = 8'hE0;
    localparam logic [DW-1:0] IIR_XMASK = 8'h30;
    localparam logic [DW-1:0] EFR_WMASK = 8'h3F;

    // packed in protected-register index order: 0 ier, 1 fcr, 2 mcr
    localparam logic [NEXT*DW-1:0] XMASKS = {MCR_XMASK, FCR_XMASK, IER_XMASK};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IER,
        SEL_FCR_IIR,
        SEL_EFR,
        SEL_LCR,
        SEL_MCR
    } sel_e;

    typedef struct packed {
        logic            efr_we;
        logic            lcr_we;
        logic [NEXT-1:0] ext_we;
    } wr_strobe_t;

    function automatic logic [DW-1:0] merge_locked(
        input logic [DW-1:0] cur,
        input logic [DW-1:0] nxt,
        input logic [DW-1:0] mask,
        input logic          unlock
    );
        return unlock ? nxt : ((nxt & ~mask) | (cur & mask));
    endfunction

endpackage

// File: rtl/uart_efr_decode.sv
module uart_efr_decode
    import uart_efr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         addr,
    input  logic                  we,
    input  logic [DW-1:0]         lcr,
    output sel_e                  sel,
    output wr_strobe_t            stb
);

    logic keyed;
    assign keyed = (lcr == ACCESS_KEY);

    always_comb begin
        unique case (addr)
            A_IER:   sel = SEL_IER;
            A_FCR:   sel = keyed ? SEL_EFR : SEL_FCR_IIR;
            A_LCR:   sel = SEL_LCR;
            A_MCR:   sel = SEL_MCR;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        stb           = '0;
        stb.efr_we    = we && (sel == SEL_EFR);
        stb.lcr_we    = we && (sel == SEL_LCR);
        stb.ext_we[0] = we && (sel == SEL_IER);
        stb.ext_we[1] = we && (sel == SEL_FCR_IIR);
        stb.ext_we[2] = we && (sel == SEL_MCR);
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.efr_we, stb.lcr_we, stb.ext_we})) else $error("strobe"); // R9
    AST_EFR_KEYED: assert property (@(posedge clk) disable iff (rst)
        stb.efr_we |-> (lcr == ACCESS_KEY)) else $error("efr key");  // R2

endmodule

// File: rtl/uart_efr_ext_reg.sv
module uart_efr_ext_reg
    import uart_efr_pkg::*;
#(
    parameter logic [DW-1:0] XMASK = 8'h00
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          unlock,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= merge_locked(q, wdata, XMASK, unlock);
    end

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (we && !unlock) |=> ((q & XMASK) == ($past(q) & XMASK))) else $error("hold"); // R5
    AST_BASE_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & ~XMASK) == ($past(wdata) & ~XMASK))) else $error("base");    // R5
    AST_EXT_OPEN: assert property (@(posedge clk) disable iff (rst)
        (we && unlock) |=> (q == $past(wdata))) else $error("open");               // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q)) else $error("idle");                                     // R7

endmodule

// File: rtl/uart_efr_read_mux.sv
module uart_efr_read_mux
    import uart_efr_pkg::*;
(
    input  sel_e                  sel,
    input  logic [DW-1:0]         efr,
    input  logic [DW-1:0]         lcr,
    input  logic [NEXT-1:0][DW-1:0] ext_q,
    input  logic [DW-1:0]         core_iir,
    output logic [DW-1:0]         rdata
);

    logic [DW-1:0] iir_view;
    assign iir_view = efr[ENH_BIT] ? core_iir : (core_iir & ~IIR_XMASK);

    always_comb begin
        unique case (sel)
            SEL_IER:     rdata = ext_q[0];
            SEL_FCR_IIR: rdata = iir_view;
            SEL_EFR:     rdata = efr;
            SEL_LCR:     rdata = lcr;
            SEL_MCR:     rdata = ext_q[2];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_efr_gate.sv
module uart_efr_gate
    import uart_efr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          host_we,
    output logic [7:0]    host_rdata,
    input  logic [7:0]    core_iir,
    output logic [7:0]    efr_q,
    output logic [7:0]    lcr_q,
    output logic [7:0]    ier_q,
    output logic [7:0]    fcr_q,
    output logic [7:0]    mcr_q
);

    sel_e                     sel;
    wr_strobe_t               stb;
    logic [NEXT-1:0][DW-1:0]  ext_q;
    logic                     unlock;

    uart_efr_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .addr (host_addr),
        .we   (host_we),
        .lcr  (lcr_q),
        .sel  (sel),
        .stb  (stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            efr_q <= '0;
            lcr_q <= '0;
        end else begin
            if (stb.efr_we) efr_q <= host_wdata & EFR_WMASK;
            if (stb.lcr_we) lcr_q <= host_wdata;
        end
    end

    assign unlock = efr_q[ENH_BIT];

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        uart_efr_ext_reg #(.XMASK(XMASKS[g*DW +: DW])) u_reg (
            .clk    (clk),
            .rst    (rst),
            .we     (stb.ext_we[g]),
            .unlock (unlock),
            .wdata  (host_wdata),
            .q      (ext_q[g])
        );
    end

    assign ier_q = ext_q[0];
    assign fcr_q = ext_q[1];
    assign mcr_q = ext_q[2];

    uart_efr_read_mux u_rmux (
        .sel      (sel),
        .efr      (efr_q),
        .lcr      (lcr_q),
        .ext_q    (ext_q),
        .core_iir (core_iir),
        .rdata    (host_rdata)
    );

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (efr_q == 8'h00 && ier_q == 8'h00 && fcr_q == 8'h00 && mcr_q == 8'h00)) else $error("rst"); // R1
    AST_EFR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        efr_q[7:6] == 2'b00) else $error("efr top");                                                  // R4
    AST_EFR_UNKEYED: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == A_FCR && lcr_q != ACCESS_KEY) |=> $stable(efr_q)) else $error("unkeyed"); // R2
    AST_IIR_MASKED: assert property (@(posedge clk) disable iff (rst)
        (host_addr == A_FCR && lcr_q != ACCESS_KEY && !efr_q[ENH_BIT]) |-> host_rdata[5:4] == 2'b00) else $error("iir"); // R8
    AST_KEYED_READ: assert property (@(posedge clk) disable iff (rst)
        (host_addr == A_FCR && lcr_q == ACCESS_KEY) |-> host_rdata == efr_q) else $error("keyed read"); // R3

endmodule

// File: tb/uart_efr_gate_tb.sv
`timescale 1ns/100ps
module uart_efr_gate_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] host_addr;
    logic [7:0] host_wdata;
    logic       host_we;
    logic [7:0] host_rdata;
    logic [7:0] core_iir;
    logic [7:0] efr_q, lcr_q, ier_q, fcr_q, mcr_q;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [7:0] m_efr, m_lcr, m_ier, m_fcr, m_mcr;

    always #4 clk = ~clk;

    uart_efr_gate u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .core_iir(core_iir),
        .efr_q(efr_q), .lcr_q(lcr_q), .ier_q(ier_q), .fcr_q(fcr_q), .mcr_q(mcr_q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lockw(input logic [7:0] cur, input logic [7:0] nxt,
                                         input logic [7:0] mask);
        return m_efr[4] ? nxt : ((nxt & ~mask) | (cur & mask));
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a, input logic [7:0] iir);
        case (a)
            3'd1: return m_ier;
            3'd2: return (m_lcr == 8'hBF) ? m_efr : (m_efr[4] ? iir : (iir & 8'hCF));
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd1: m_ier = lockw(m_ier, d, 8'hF0);
            3'd2: if (m_lcr == 8'hBF) m_efr = d & 8'h3F;
                  else m_fcr = lockw(m_fcr, d, 8'h30);
            3'd3: m_lcr = d;
            3'd4: m_mcr = lockw(m_mcr, d, 8'hE0);
            default: ;
        endcase
    endtask

    task automatic check_state(input string tag);
        check({tag, " R2 efr"}, efr_q, m_efr);
        check({tag, " R9 lcr"}, lcr_q, m_lcr);
        check({tag, " R5 ier"}, ier_q, m_ier);
        check({tag, " R5 fcr"}, fcr_q, m_fcr);
        check({tag, " R5 mcr"}, mcr_q, m_mcr);
    endtask

    // one bus cycle: drive at negedge, check read combinationally, update at edge
    task automatic cycle(input logic [2:0] a, input logic [7:0] d, input logic we,
                         input logic [7:0] iir, input string tag);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = we; core_iir = iir;
        #1;
        check({tag, " R3 rdata"}, host_rdata, exp_rd(a, iir));
        @(posedge clk);
        if (we) model_write(a, d);
        @(negedge clk);
        host_we = 1'b0;
        #1;
        check_state(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0101));
        rst = 1'b1; host_addr = '0; host_wdata = '0; host_we = 1'b0; core_iir = '0;
        m_efr = 0; m_lcr = 0; m_ier = 0; m_fcr = 0; m_mcr = 0;
        repeat (3) @(posedge clk);
        // dirty some state, then reset again to see R1
        @(negedge clk); rst = 1'b0;
        cycle(3'd3, 8'hBF, 1, 8'h00, "pre");
        cycle(3'd2, 8'h10, 1, 8'h00, "pre");
        cycle(3'd1, 8'hFF, 1, 8'h00, "pre");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        m_efr = 0; m_lcr = 0; m_ier = 0; m_fcr = 0; m_mcr = 0;
        #1;
        check("R1 efr", efr_q, 8'h00); check("R1 ier", ier_q, 8'h00);
        check("R1 fcr", fcr_q, 8'h00); check("R1 mcr", mcr_q, 8'h00);
        check("R1 lcr", lcr_q, 8'h00);

        // R5: enable off, extended fields held
        cycle(3'd1, 8'hFF, 1, 8'h00, "R5");
        check("R5 ier base only", ier_q, 8'h0F);
        cycle(3'd4, 8'hFF, 1, 8'h00, "R5");
        check("R5 mcr base only", mcr_q, 8'h1F);
        // R2: address 2 unkeyed goes to FCR
        cycle(3'd2, 8'hFF, 1, 8'h00, "R2");
        check("R2 fcr unkeyed", fcr_q, 8'hCF);
        check("R2 efr untouched", efr_q, 8'h00);
        // R8 masked view
        cycle(3'd2, 8'h00, 0, 8'hFF, "R8");
        check("R8 iir masked", host_rdata, 8'hCF);
        // key in, R4 top bits
        cycle(3'd3, 8'hBF, 1, 8'h00, "R2");
        cycle(3'd2, 8'hFF, 1, 8'h00, "R4");
        check("R4 efr top zero", efr_q, 8'h3F);
        cycle(3'd2, 8'h00, 0, 8'h00, "R3");
        check("R3 keyed read efr", host_rdata, 8'h3F);
        // R6: open writes
        cycle(3'd1, 8'hA5, 1, 8'h00, "R6");
        check("R6 ier full", ier_q, 8'hA5);
        cycle(3'd4, 8'hC3, 1, 8'h00, "R6");
        check("R6 mcr full", mcr_q, 8'hC3);
        cycle(3'd3, 8'h03, 1, 8'h00, "R6");
        cycle(3'd2, 8'h31, 1, 8'h00, "R6");
        check("R6 fcr full", fcr_q, 8'h31);
        cycle(3'd2, 8'h00, 0, 8'h3C, "R8");
        check("R8 iir open", host_rdata, 8'h3C);
        // R7: freeze
        cycle(3'd3, 8'hBF, 1, 8'h00, "R7");
        cycle(3'd2, 8'h00, 1, 8'h00, "R7");
        cycle(3'd3, 8'h03, 1, 8'h00, "R7");
        for (int i = 0; i < 4; i++) begin
            cycle(3'd1, 8'h00, 1, 8'h00, "R7");
            cycle(3'd4, 8'h00, 1, 8'h00, "R7");
            cycle(3'd2, 8'h00, 1, 8'h00, "R7");
        end
        check("R7 ier frozen", ier_q, 8'hA0);
        check("R7 mcr frozen", mcr_q, 8'hC0);
        check("R7 fcr frozen", fcr_q, 8'h30);
        // R9 unused addresses
        cycle(3'd5, 8'hFF, 1, 8'hFF, "R9");
        check("R9 unused read", host_rdata, 8'h00);
        cycle(3'd0, 8'hFF, 1, 8'hFF, "R9");
        cycle(3'd7, 8'hFF, 1, 8'hFF, "R9");

        // random mix, key held often
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            logic       w;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            w = ($urandom_range(0, 3) != 0);
            if (a == 3'd3 && ($urandom_range(0, 1) == 0)) d = 8'hBF;
            cycle(a, d, w, 8'($urandom), "rand");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule